// File: doc/BRIEF.md
# Escalation Domain Timeout Monitor

This block watches over a separately clocked escalation network from the local clock domain. It keeps a request/acknowledge exchange running with that network at all times. Each acknowledge transition shows that the remote clock and reset are alive. If the remote side goes silent for a fixed number of local cycles, the monitor assumes the escalation network is dead. It then raises an escalation of its own, so the loss of that network cannot leave a real escalation unserviced.

The request is a toggle signal. The monitor inverts the request once the synchronized acknowledge has caught up with it. The remote responder only has to echo the request back through its own synchronizer. A cycle counter measures the gap since the last acknowledge transition. When the gap reaches the timeout, a sticky fault is set, and only a local reset clears it. The combined output is the OR of that fault and the synchronized incoming escalation. A power sequencer uses this output to jump straight into reset handling from any state, without going through its normal graceful sequence.

Top module: `esc_timeout_mon`

## Requirements
- R1: While `rst_i` is sampled high at a clock edge, `esc_req_o` and `esc_out_o` are both 0 after that edge.
- R2: The request toggles continuously. After an edge where the synchronized acknowledge equals `esc_req_o`, the request is inverted. Otherwise it holds its value.
- R3: `esc_ack_i` passes through a two-flop synchronizer before use. A value of `esc_ack_i` sampled at edge k is first seen by the request logic at edge k+2, so `esc_req_o` can first change after edge k+2.
- R4: The gap counter clears on every transition of the synchronized acknowledge. It saturates at TIMEOUT (default 128). While transitions arrive less than TIMEOUT cycles apart, no fault is raised.
- R5: The fault is raised after TIMEOUT consecutive cycles with no acknowledge transition. The counter reaches TIMEOUT, and `esc_out_o` goes to 1 after the following edge.
- R6: Once raised, the fault stays set even if acknowledges resume. Only a local reset clears it.
- R7: `esc_in_i` passes through a two-flop synchronizer. A 1 sampled at edge k appears on `esc_out_o` after edge k+1 and is not latched.
- R8: `esc_out_o` equals the OR of the latched fault and the synchronized `esc_in_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local clock |
| rst_i | input | 1 | Synchronous active-high local reset |
| esc_req_o | output | 1 | Toggle request sent to the escalation domain |
| esc_ack_i | input | 1 | Acknowledge echoed back from the escalation domain (asynchronous) |
| esc_in_i | input | 1 | Incoming escalation request (asynchronous) |
| esc_out_o | output | 1 | Combined escalation: timeout fault OR incoming escalation |

## Verification
The assertions check, on every cycle, the following properties:
- the request holds or flips according to the synchronized acknowledge;
- the gap counter stays bounded and clears after each acknowledge transition;
- the fault fires once the counter saturates and never releases afterwards;
- the output covers the fault;
- reset clears both outputs.

Only the bench scenarios can show the end-to-end behaviour. These scenarios include a healthy remote domain that never trips, a frozen remote clock and a remote held in reset that both trip after the timeout, and acknowledges that resume without clearing the fault. They also cover the synchronizer latency and the pulse that an incoming escalation produces.

// File: rtl/esc_mon_pkg.sv
package esc_mon_pkg;

    // Health of the remote escalation domain as seen locally.
    typedef enum logic {
        WD_ALIVE = 1'b0,
        WD_DEAD  = 1'b1
    } wd_state_e;

    // The two asynchronous inputs synchronized as one bundle.
    typedef struct packed {
        logic esc;
        logic ack;
    } remote_sig_t;

    localparam int unsigned REMOTE_SIG_W = $bits(remote_sig_t);

    // Counter width needed to hold values 0..limit.
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/esc_mon_sync.sv
module esc_mon_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[s] <= '0;
                    else       stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[s] <= '0;
                    else       stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/esc_mon_handshake.sv
module esc_mon_handshake (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ack_sync_i,
    output logic req_o,
    output logic ack_edge_o
);

    logic req_q;
    logic ack_prev_q;

    // Flip the request whenever the echoed acknowledge has caught up.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_q      <= 1'b0;
            ack_prev_q <= 1'b0;
        end else begin
            ack_prev_q <= ack_sync_i;
            if (ack_sync_i == req_q) req_q <= ~req_q;
        end
    end

    assign req_o      = req_q;
    assign ack_edge_o = ack_sync_i ^ ack_prev_q;

    assert_req_wait_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_sync_i != req_q) |=> $stable(req_q));

    assert_req_flip_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_sync_i == req_q) |=> (req_q != $past(req_q)));

endmodule

// File: rtl/esc_mon_watchdog.sv
module esc_mon_watchdog
    import esc_mon_pkg::*;
#(
    parameter int unsigned TIMEOUT = 128,
    parameter int unsigned CNT_W   = cnt_width(TIMEOUT)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ack_edge_i,
    output logic fault_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

    logic [CNT_W-1:0] gap_q;
    wd_state_e        state_q;
    logic             at_limit;

    assign at_limit = (gap_q == LIMIT);

    // Cycles since the last acknowledge transition; sticks at the limit.
    always_ff @(posedge clk_i) begin
        if (rst_i)           gap_q <= '0;
        else if (ack_edge_i) gap_q <= '0;
        else if (!at_limit)  gap_q <= gap_q + 1'b1;
    end

    // Sticky fault; only a local reset brings the domain back to alive.
    always_ff @(posedge clk_i) begin
        if (rst_i)         state_q <= WD_ALIVE;
        else if (at_limit) state_q <= WD_DEAD;
    end

    assign fault_o = (state_q == WD_DEAD);

    assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        gap_q <= LIMIT);

    assert_cnt_clear_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        ack_edge_i |=> (gap_q == '0));

    assert_fire_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        at_limit |=> fault_o);

    assert_latch_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        fault_o |=> fault_o);

endmodule

// File: rtl/esc_timeout_mon.sv
module esc_timeout_mon
    import esc_mon_pkg::*;
#(
    parameter int unsigned TIMEOUT     = 128,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic esc_req_o,
    input  logic esc_ack_i,
    input  logic esc_in_i,
    output logic esc_out_o
);

    localparam int unsigned CNT_W = cnt_width(TIMEOUT);

    remote_sig_t raw_sig;
    remote_sig_t sync_sig;
    logic        ack_edge;
    logic        fault;

    assign raw_sig.ack = esc_ack_i;
    assign raw_sig.esc = esc_in_i;

    esc_mon_sync #(
        .WIDTH  (REMOTE_SIG_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (raw_sig),
        .sync_o  (sync_sig)
    );

    esc_mon_handshake u_hs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ack_sync_i (sync_sig.ack),
        .req_o      (esc_req_o),
        .ack_edge_o (ack_edge)
    );

    esc_mon_watchdog #(
        .TIMEOUT (TIMEOUT),
        .CNT_W   (CNT_W)
    ) u_wd (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ack_edge_i (ack_edge),
        .fault_o    (fault)
    );

    assign esc_out_o = fault | sync_sig.esc;

    assert_reset_R1: assert property (@(posedge clk_i)
        rst_i |=> (!esc_req_o && !esc_out_o));

    assert_out_fault_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        fault |-> esc_out_o);

    assert_out_esc_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_sig.esc |-> esc_out_o);

endmodule

// File: tb/esc_timeout_mon_bench.sv
module esc_timeout_mon_bench;

    localparam int TIMEOUT = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic esc_ack;
    logic esc_in = 1'b0;
    logic esc_req;
    logic esc_out;

    // Remote escalation domain responder (edges at even ns only).
    logic rclk = 1'b0;
    logic rclk_en = 1'b1;
    logic rrst = 1'b0;
    logic r1 = 1'b0, r2 = 1'b0;

    int compared = 0;
    int mismatched = 0;
    int req_toggles = 0;
    bit running = 1'b0;

    always #5 clk = ~clk;
    initial begin
        #2;
        forever #8 rclk = ~rclk;
    end

    always @(posedge rclk) begin
        if (rrst) begin
            r1 <= 1'b0;
            r2 <= 1'b0;
        end else if (rclk_en) begin
            r1 <= esc_req;
            r2 <= r1;
        end
    end
    assign esc_ack = r2;

    esc_timeout_mon #(.TIMEOUT(TIMEOUT)) u_esc_timeout_mon (
        .clk_i     (clk),
        .rst_i     (rst),
        .esc_req_o (esc_req),
        .esc_ack_i (esc_ack),
        .esc_in_i  (esc_in),
        .esc_out_o (esc_out)
    );

    // Behavioural reference model, advanced at every local edge.
    bit ack_hist[$];
    bit esc_hist[$];
    bit m_ack_seen, m_ack_last, m_req, m_dead, m_out;
    int m_gap;

    always @(posedge clk) begin
        bit seen_before;
        seen_before = m_ack_seen;
        if (rst) begin
            ack_hist.delete();
            esc_hist.delete();
            m_ack_seen = 0; m_ack_last = 0; m_req = 0;
            m_dead = 0; m_gap = 0; m_out = 0;
        end else begin
            if (m_gap >= TIMEOUT) m_dead = 1;
            if (seen_before != m_ack_last) m_gap = 0;
            else if (m_gap < TIMEOUT) m_gap++;
            if (seen_before == m_req) m_req = !m_req;
            m_ack_last = seen_before;
            ack_hist.push_back(esc_ack);
            esc_hist.push_back(esc_in);
            while (ack_hist.size() > 2) void'(ack_hist.pop_front());
            while (esc_hist.size() > 2) void'(esc_hist.pop_front());
            m_ack_seen = (ack_hist.size() == 2) ? ack_hist[0] : 1'b0;
            m_out = m_dead | ((esc_hist.size() == 2) ? esc_hist[0] : 1'b0);
        end
    end

    // Per-cycle comparison against the model.
    bit last_req = 1'b0;
    always @(negedge clk) begin
        if (running) begin
            compared += 2;
            if (esc_req !== m_req) begin
                mismatched++;
                $display("FAIL R2 R3 req actual=%0b expected=%0b t=%0t", esc_req, m_req, $time);
            end
            if (esc_out !== m_out) begin
                mismatched++;
                $display("FAIL R8 out actual=%0b expected=%0b t=%0t", esc_out, m_out, $time);
            end
            if (esc_req !== last_req) req_toggles++;
            last_req = esc_req;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic local_reset(input int n);
        rst = 1'b1;
        cycles(n);
        check("R1 req in reset", esc_req, 1'b0);
        check("R6 out cleared by reset", esc_out, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        mismatched++;
        $display("FAIL watchdog expired t=%0t", $time);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        cycles(3);
        check("R1 reset req", esc_req, 1'b0);
        check("R1 reset out", esc_out, 1'b0);
        rst = 1'b0;
        running = 1'b1;

        // Healthy remote: request keeps toggling, no fault (R2, R4).
        cycles(1500);
        check("R4 healthy no fault", esc_out, 1'b0);
        check("R2 request toggles", req_toggles > 50, 1'b1);

        // One-cycle incoming escalation: pulse after sync, not latched (R7).
        esc_in = 1'b1;
        cycles(1);
        esc_in = 1'b0;
        cycles(1);
        check("R7 esc pulse seen", esc_out, 1'b1);
        cycles(3);
        check("R7 esc not latched", esc_out, 1'b0);

        // Long incoming escalation follows the level (R8).
        esc_in = 1'b1;
        cycles(20);
        check("R8 esc level", esc_out, 1'b1);
        esc_in = 1'b0;
        cycles(5);
        check("R8 esc released", esc_out, 1'b0);

        // Frozen remote clock: no early fault, then fault (R5).
        rclk_en = 1'b0;
        cycles(60);
        check("R5 no early fault", esc_out, 1'b0);
        cycles(200);
        check("R5 timeout fault", esc_out, 1'b1);

        // Remote comes back: fault stays (R6).
        rclk_en = 1'b1;
        cycles(400);
        check("R6 fault sticky", esc_out, 1'b1);
        esc_in = 1'b1;
        cycles(4);
        esc_in = 1'b0;
        cycles(4);
        check("R8 fault and esc", esc_out, 1'b1);

        // Local reset clears; healthy again (R6, R4).
        local_reset(2);
        cycles(600);
        check("R4 healthy after reset", esc_out, 1'b0);

        // Remote held in reset: acknowledge stuck, fault (R5).
        rrst = 1'b1;
        cycles(300);
        check("R5 remote reset fault", esc_out, 1'b1);
        rrst = 1'b0;
        cycles(100);
        check("R6 sticky after remote reset", esc_out, 1'b1);

        local_reset(3);
        cycles(500);
        check("R4 final healthy", esc_out, 1'b0);

        running = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule